// File: doc/BRIEF.md
# Word-Addressed Next Instruction Address Unit

This block produces the instruction-memory address of a 32-bit processor. The program counter is kept as a word address only, because every instruction is four bytes and aligned. The two low byte-address bits are never stored and are always driven as zero on the output. Each clock edge loads the counter with the next address. That address is the following word, or, when a branch is taken, the following word plus a sign-extended 16-bit word offset.

The sequential address and the branch target come from one adder. The carry-in of the adder is tied high, and this supplies the "+1 word". The second operand is either zero or the sign-extended offset. A branch is taken only when the decoded branch control and the ALU zero flag are both high. A hold input freezes the counter, and a synchronous reset returns it to the reset word. The adder's carry-out is dropped, so addresses wrap around the top of the word space.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the counter loads the reset word (default 0), so `imem_addr` reads 0x00000000 after that edge.
- R2: `imem_addr[1:0]` is always 2'b00, and `imem_addr[31:2]` is the 30-bit word counter.
- R3: When reset and hold are low and no branch is taken, `imem_addr` grows by 4 at each rising edge.
- R4: When `br_en` and `alu_zero` are both 1 (and reset and hold are low), the next `imem_addr` is the current address + 4 + 4 × offset.
- R5: If only one of `br_en` or `alu_zero` is 1, no branch is taken and the offset has no effect: the address grows by 4.
- R6: `br_offset` is a two's-complement word offset. Bit 15 is the sign bit, so 16'hFFFE moves back by one word after the increment, and 16'h8000 is −32768 words.
- R7: Word addresses wrap modulo 2^30. Address 0xFFFFFFFC followed by a sequential step gives 0x00000000, and branch targets wrap in the same way.
- R8: While `hold` is high (and reset is low), `imem_addr` keeps its value, even when a branch is taken.
- R9: Reset has priority over hold. With both high, the counter still loads the reset word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Freeze the counter when high |
| br_en | input | 1 | Decoded branch control for the current instruction |
| alu_zero | input | 1 | ALU zero flag (branch condition met) |
| br_offset | input | 16 | Signed word offset, instruction bits [15:0] |
| imem_addr | output | 32 | Registered instruction-memory byte address |

## Verification
The counter is the only state, and it is exposed directly on `imem_addr`. A wrong next-address decision therefore shows at the ports on the first edge after the bad inputs: a missing increment, a bad sign extension, a wrong branch condition, or a hold or reset priority error. That error also carries into every later address, because each address is built from the one before it. The bench predicts every address from its own word-counter model and compares each one cycle after it drives the inputs. It also aims at the points where a single-bit slip is hidden in normal runs: the sign bit of the offset, the wrap at the top of the word space, and hold combined with a taken branch.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned NPC_ADDR_W   = 32;
  localparam int unsigned NPC_IMM_W    = 16;
  localparam int unsigned NPC_BYTE_LSB = 2;

  typedef enum logic [1:0] {
    NPC_RESET = 2'd0,
    NPC_HOLD  = 2'd1,
    NPC_STEP  = 2'd2
  } npc_load_e;
endpackage

// File: rtl/npc_sext.sv
module npc_sext #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 30
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  generate
    if (OUT_W > IN_W) begin : g_widen
      localparam int unsigned PAD_W = OUT_W - IN_W;
      assign dout = {{PAD_W{din[IN_W-1]}}, din};
    end else begin : g_trim
      assign dout = din[OUT_W-1:0];
    end
  endgenerate

  // R6: the upper bits all copy the sign bit
  generate
    if (OUT_W > IN_W) begin : g_chk
      always_comb begin
        p_sign_fill_r6: assert ($countones(dout[OUT_W-1:IN_W-1]) == 0 ||
                                $countones(dout[OUT_W-1:IN_W-1]) == OUT_W-IN_W+1);
      end
    end
  endgenerate
endmodule

// File: rtl/npc_opsel.sv
module npc_opsel #(
  parameter int unsigned W = 30
) (
  input  logic         br_en,
  input  logic         alu_zero,
  input  logic [W-1:0] ext_off,
  output logic         take,
  output logic [W-1:0] operand
);
  assign take = br_en & alu_zero;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_gate
      assign operand[i] = ext_off[i] & take;
    end
  endgenerate

  // R5: only one of the two conditions high yields a zero operand
  always_comb begin
    p_half_cond_r5: assert (!(br_en ^ alu_zero) || operand == '0);
  end
endmodule

// File: rtl/npc_adder.sv
module npc_adder #(
  parameter int unsigned W = 30
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);
  logic [W-1:0] cin_vec;
  assign cin_vec = {{(W-1){1'b0}}, cin};
  // carry-out dropped on purpose: addresses wrap (R7)
  assign sum = a + b + cin_vec;
endmodule

// File: rtl/npc_pcreg.sv
module npc_pcreg
  import npc_pkg::*;
#(
  parameter int unsigned W          = 30,
  parameter logic [W-1:0] RESET_WORD = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  npc_load_e sel;

  always_comb begin
    if (rst)       sel = NPC_RESET;
    else if (hold) sel = NPC_HOLD;
    else           sel = NPC_STEP;
  end

  always_ff @(posedge clk) begin
    case (sel)
      NPC_RESET: q <= RESET_WORD;
      NPC_HOLD:  q <= q;
      default:   q <= d;
    endcase
  end

  // R1 / R9: reset wins over hold
  p_reset_load_r1: assert property (@(posedge clk) rst |=> q == RESET_WORD);
  // R8: hold freezes the word counter
  p_hold_freeze_r8: assert property (@(posedge clk) disable iff (rst)
                                     hold |=> $stable(q));
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned ADDR_W     = NPC_ADDR_W,
  parameter int unsigned IMM_W      = NPC_IMM_W,
  parameter int unsigned BYTE_LSB   = NPC_BYTE_LSB,
  parameter logic [ADDR_W-BYTE_LSB-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              br_en,
  input  logic              alu_zero,
  input  logic [IMM_W-1:0]  br_offset,
  output logic [ADDR_W-1:0] imem_addr
);
  localparam int unsigned WORD_W = ADDR_W - BYTE_LSB;
  localparam logic [WORD_W-1:0] ONE_WORD = {{(WORD_W-1){1'b0}}, 1'b1};

  logic [WORD_W-1:0] pc_q;
  logic [WORD_W-1:0] ext_off;
  logic [WORD_W-1:0] operand;
  logic [WORD_W-1:0] pc_next;
  logic              take;

  npc_sext #(.IN_W(IMM_W), .OUT_W(WORD_W)) u_sext (
    .din  (br_offset),
    .dout (ext_off)
  );

  npc_opsel #(.W(WORD_W)) u_opsel (
    .br_en    (br_en),
    .alu_zero (alu_zero),
    .ext_off  (ext_off),
    .take     (take),
    .operand  (operand)
  );

  npc_adder #(.W(WORD_W)) u_add (
    .a   (pc_q),
    .b   (operand),
    .cin (1'b1),
    .sum (pc_next)
  );

  npc_pcreg #(.W(WORD_W), .RESET_WORD(RESET_WORD)) u_pc (
    .clk  (clk),
    .rst  (rst),
    .hold (hold),
    .d    (pc_next),
    .q    (pc_q)
  );

  assign imem_addr = {pc_q, {BYTE_LSB{1'b0}}};

  // R3 / R5: no branch taken -> one word forward, wrapping (R7)
  p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!hold && !(br_en && alu_zero)) |=>
      imem_addr[ADDR_W-1:BYTE_LSB] == WORD_W'($past(imem_addr[ADDR_W-1:BYTE_LSB]) + ONE_WORD));

  // R4 / R6: taken branch -> one word plus signed offset
  p_taken_target_r4: assert property (@(posedge clk) disable iff (rst)
    (!hold && br_en && alu_zero) |=>
      imem_addr[ADDR_W-1:BYTE_LSB] == WORD_W'($past(imem_addr[ADDR_W-1:BYTE_LSB]) + ONE_WORD +
        WORD_W'($signed($past(br_offset)))));

  // R2: byte offset bits stay zero after reset
  p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    imem_addr[BYTE_LSB-1:0] == '0);
endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hold = 1'b0;
  logic        br_en = 1'b0;
  logic        alu_zero = 1'b0;
  logic [15:0] br_offset = '0;
  logic [31:0] imem_addr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] addr;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [29:0] mpc = '0;

  always #4 clk = ~clk;

  npc_unit uut (
    .clk(clk), .rst(rst), .hold(hold), .br_en(br_en),
    .alu_zero(alu_zero), .br_offset(br_offset), .imem_addr(imem_addr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: drive one cycle of inputs, push the predicted address
  task automatic step(input logic r, input logic h, input logic b, input logic z,
                      input logic [15:0] off, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; hold = h; br_en = b; alu_zero = z; br_offset = off;
    if (r)           mpc = '0;
    else if (h)      mpc = mpc;
    else if (b && z) mpc = mpc + 30'd1 + {{14{off[15]}}, off};
    else             mpc = mpc + 30'd1;
    e.addr = {mpc, 2'b00};
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // monitor: compare just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, imem_addr, e.addr);
        check("R2 alignment", {30'd0, imem_addr[1:0]}, 32'd0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    step(1, 0, 0, 0, 16'h0000, "R1 reset");
    step(1, 0, 0, 0, 16'h0000, "R1 reset");
    step(0, 0, 0, 0, 16'h0000, "R3 sequential");
    step(0, 0, 0, 0, 16'h1234, "R3 sequential");
    step(0, 0, 0, 0, 16'h0000, "R3 sequential");
    step(0, 0, 1, 1, 16'h0005, "R4 forward branch");
    step(0, 0, 1, 0, 16'h0040, "R5 branch without zero");
    step(0, 0, 0, 1, 16'h0040, "R5 zero without branch");
    step(0, 0, 1, 1, 16'hFFFE, "R6 backward branch");
    step(0, 0, 1, 1, 16'h0000, "R4 zero offset");
    step(0, 1, 1, 1, 16'h0100, "R8 hold over taken branch");
    step(0, 1, 0, 0, 16'h0000, "R8 hold");
    step(0, 0, 1, 1, 16'h8000, "R6 most negative offset");
    step(0, 0, 1, 1, 16'h7FFF, "R6 most positive offset");
    step(1, 1, 1, 1, 16'h0020, "R9 reset over hold");
    step(0, 0, 0, 0, 16'h0000, "R3 after reset");
    step(0, 0, 1, 1, 16'hFFFD, "R7 branch wraps below zero");
    step(0, 0, 0, 0, 16'h0000, "R7 sequential wraps to zero");
    step(0, 0, 1, 1, 16'hFFFE, "R7 branch to top word");
    for (int i = 0; i < 200; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(1'b0, lf[0] & lf[5], lf[1], lf[2], {lf[7:0], lf[15:8]}, "R4 mixed pattern");
    end
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule